// File: doc/BRIEF.md
# Row-Stationary 2D Convolution Engine

This block computes a single-channel 2D convolution of a square integer feature map with a square integer kernel. It produces one output pixel per cycle from a row-stationary array of processing elements. Each processing element owns one kernel row. It performs a complete 1D convolution of one image row against that kernel row, and all of them work in the same cycles. The per-row partial sums are added in one registered stage to form each output pixel. Stride is one and there is no padding, so an N×N map and a K×K kernel give (N-K+1)×(N-K+1) outputs.

The map arrives as bands. A band is K adjacent image rows, presented one column slice per cycle on a K-lane pixel port. A two-state sequencer counts columns and bands. It starts on `en` and then takes a slice on every cycle until all N-K+1 bands are in. Kernel coefficients are written one at a time through a small write port while the engine is idle. Results leave with a valid flag, and a one-cycle end flag marks the last pixel of a map.

Top module: `conv_rs_array`

## Requirements
- R1: After synchronous reset `out_valid`, `done` and `out_data` are all 0 and the engine is idle.
- R2: Each output equals the signed sum over k,t in 0..K-1 of w[k][t]·p[r+k][j+t]. Pixels and weights are 8-bit two's complement. `pix_in` lane k (bits 8k+7..8k) carries image row r+k of the current band. Weight address k·K+t holds w[k][t].
- R3: With K=3, the first output of every band is valid exactly 3 cycles after the band's first column slice is sampled.
- R4: Every band yields exactly N-K+1 outputs, in increasing column order. No valid output appears outside them.
- R5: Once started, the engine takes one slice per cycle for N·(N-K+1) consecutive cycles. The cycle in which `en` is seen counts as the first of them, and each band's outputs fall on consecutive cycles.
- R6: `en` has no effect while a map is being streamed.
- R7: `done` is a one-cycle pulse that coincides with the last valid output of a map and is never high at any other time.
- R8: Weight writes are ignored while a map is being streamed and take effect when the engine is idle.
- R9: Accumulation is 20-bit signed and does not overflow for extreme values (all -128 pixels against all -128 weights gives 147456; against all 127 weights gives -146304).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Start request; the slice on `pix_in` in this cycle is the first one |
| pix_in | input | 8·K | One column slice of the current band, lane k = image row offset k |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | clog2(K·K+1) | Weight index k·K+t |
| wt_data | input | 8 | Signed weight value |
| out_data | output | 20 | Signed convolution result, 0 when not valid |
| out_valid | output | 1 | `out_data` holds a result |
| done | output | 1 | Pulse with the final result of a map |

## Verification
The output for column o of band b is due exactly K + b·N + o cycles after the edge that samples the start slice, with K = 3 here. Every expected pixel carries this due cycle. The driver computes the due cycle from the cycle count when it issues `en` and puts it in a scoreboard queue along with the value and the end-flag expectation. On every falling edge the monitor compares the queue head against the outputs when the head is due, and otherwise requires `out_valid` and `done` to be low. Early, late, missing or extra results therefore all fail a check.

// File: rtl/conv_rs_pkg.sv
package conv_rs_pkg;

    localparam int PIX_W = 8;
    localparam int WGT_W = 8;
    localparam int ACC_W = 20;

    typedef logic signed [PIX_W-1:0] pix_t;
    typedef logic signed [WGT_W-1:0] wgt_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // tag that travels alongside a slice whose row sums complete an output
    typedef struct packed {
        logic vld;
        logic last;
    } beat_tag_t;

    function automatic acc_t mac_step(acc_t acc_in, pix_t px, wgt_t wt);
        acc_t prod;
        prod = acc_t'(px) * acc_t'(wt);
        return acc_in + prod;
    endfunction

endpackage

// File: rtl/rs_mac_cell.sv
module rs_mac_cell
    import conv_rs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pix_t px,
    input  wgt_t wt,
    input  acc_t psum_in,
    output acc_t psum_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            psum_out <= '0;
        end else begin
            psum_out <= mac_step(psum_in, px, wt);
        end
    end

endmodule

// File: rtl/rs_row_pe.sv
module rs_row_pe
    import conv_rs_pkg::*;
#(
    parameter int K = 3
) (
    input  logic clk,
    input  logic rst,
    input  pix_t px,
    input  wgt_t wt_row [K],
    output acc_t row_sum
);

    // transposed 1D systolic chain: the pixel is broadcast, partial sums ripple
    acc_t link [K+1];

    assign link[0] = '0;

    for (genvar t = 0; t < K; t++) begin : g_tap
        rs_mac_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .px       (px),
            .wt       (wt_row[t]),
            .psum_in  (link[t]),
            .psum_out (link[t+1])
        );
    end

    assign row_sum = link[K];

endmodule

// File: rtl/rs_weight_bank.sv
module rs_weight_bank
    import conv_rs_pkg::*;
#(
    parameter int K = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         busy,
    input  logic                         we,
    input  logic [$clog2(K*K+1)-1:0]     addr,
    input  wgt_t                         data,
    output wgt_t                         grid [K][K]
);

    localparam int TAPS = K * K;
    localparam int AW   = $clog2(TAPS + 1);
    localparam logic [AW-1:0] ADDR_LIM = AW'(TAPS);

    wgt_t                   bank [TAPS];
    logic [TAPS*WGT_W-1:0]  flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                bank[i] <= '0;
            end
        end else if (we && !busy && (addr < ADDR_LIM)) begin
            bank[addr] <= data;
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_flat
        assign flat[i*WGT_W +: WGT_W] = bank[i];
    end

    for (genvar k = 0; k < K; k++) begin : g_row
        for (genvar t = 0; t < K; t++) begin : g_col
            assign grid[k][t] = bank[k*K + t];
        end
    end

    // R8
    weights_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(flat));

endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
    import conv_rs_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 3
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       en,
    output logic                                       busy,
    output logic                                       take,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0]       col,
    output beat_tag_t                                  tag
);

    localparam int BANDS  = N - K + 1;
    localparam int COL_W  = (N > 1) ? $clog2(N) : 1;
    localparam int BAND_W = (BANDS > 1) ? $clog2(BANDS) : 1;
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(N - 1);
    localparam logic [COL_W-1:0]  COL_FIRST = COL_W'(K - 1);
    localparam logic [BAND_W-1:0] BAND_LAST = BAND_W'(BANDS - 1);

    seq_state_e         state;
    logic [BAND_W-1:0]  band;

    assign busy = (state == SEQ_RUN);
    assign take = busy || en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            col   <= '0;
            band  <= '0;
        end else if (take) begin
            if (col == COL_LAST) begin
                col <= '0;
                if (band == BAND_LAST) begin
                    band  <= '0;
                    state <= SEQ_IDLE;
                end else begin
                    band  <= band + 1'b1;
                    state <= SEQ_RUN;
                end
            end else begin
                col   <= col + 1'b1;
                state <= SEQ_RUN;
            end
        end
    end

    always_comb begin
        tag.vld  = take && (col >= COL_FIRST);
        tag.last = take && (col == COL_LAST) && (band == BAND_LAST);
    end

    // R5
    slice_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && col != COL_LAST) |=> (busy && col == $past(col) + 1'b1));

    // R6
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && en && col != COL_LAST) |=> (col != '0));

    // R4
    idle_home_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (col == '0 && band == '0));

endmodule

// File: rtl/conv_rs_array.sv
module conv_rs_array
    import conv_rs_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic [K*PIX_W-1:0]           pix_in,
    input  logic                         wt_we,
    input  logic [$clog2(K*K+1)-1:0]     wt_addr,
    input  logic [WGT_W-1:0]             wt_data,
    output logic [ACC_W-1:0]             out_data,
    output logic                         out_valid,
    output logic                         done
);

    localparam int COL_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [COL_W-1:0] COL_FIRST = COL_W'(K - 1);

    logic              busy;
    logic              take;
    logic [COL_W-1:0]  col;
    beat_tag_t         tag_d;
    beat_tag_t         tag_q;
    wgt_t              wt_grid [K][K];
    pix_t              lane    [K];
    acc_t              row_sum [K];
    acc_t              total;

    rs_seq_fsm #(.N(N), .K(K)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .busy (busy),
        .take (take),
        .col  (col),
        .tag  (tag_d)
    );

    rs_weight_bank #(.K(K)) u_wbank (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .we   (wt_we),
        .addr (wt_addr),
        .data (wgt_t'(wt_data)),
        .grid (wt_grid)
    );

    for (genvar k = 0; k < K; k++) begin : g_pe
        assign lane[k] = pix_t'(pix_in[k*PIX_W +: PIX_W]);

        rs_row_pe #(.K(K)) u_pe (
            .clk     (clk),
            .rst     (rst),
            .px      (lane[k]),
            .wt_row  (wt_grid[k]),
            .row_sum (row_sum[k])
        );
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < K; k++) begin
            total = total + row_sum[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q     <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
            out_data  <= '0;
        end else begin
            tag_q     <= tag_d;
            out_valid <= tag_q.vld;
            done      <= tag_q.vld && tag_q.last;
            out_data  <= tag_q.vld ? total : '0;
        end
    end

    // R7
    done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    first_out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (take && col == COL_FIRST) |-> ##2 out_valid);

    // R1
    quiet_output_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

endmodule

// File: tb/conv_rs_array_bench.sv
module conv_rs_array_bench;

    localparam int N     = 8;
    localparam int K     = 3;
    localparam int BANDS = N - K + 1;
    localparam int AW    = $clog2(K*K+1);

    typedef struct {
        int     data;
        bit     last;
        longint due;
        int     col;
        string  req;
    } exp_t;

    logic             clk;
    logic             rst;
    logic             en;
    logic [K*8-1:0]   pix_in;
    logic             wt_we;
    logic [AW-1:0]    wt_addr;
    logic [7:0]       wt_data;
    logic [19:0]      out_data;
    logic             out_valid;
    logic             done;

    int     n_chk;
    int     n_fail;
    longint cyc;
    bit     mon_on;
    exp_t   sb [$];
    exp_t   cur;
    int     img [N][N];
    int     wk  [K][K];

    conv_rs_array #(.N(N), .K(K)) u_conv_rs_array (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .pix_in    (pix_in),
        .wt_we     (wt_we),
        .wt_addr   (wt_addr),
        .wt_data   (wt_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .done      (done)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                cur = sb.pop_front();
                chk(out_valid === 1'b1, (cur.col == 0) ? "R3" : "R5",
                    "out_valid at due cycle", longint'(out_valid), 1);
                chk(int'($signed(out_data)) == cur.data, cur.req,
                    "out_data", longint'(int'($signed(out_data))), cur.data);
                chk(done === cur.last, "R7", "done flag",
                    longint'(done), longint'(cur.last));
            end else begin
                chk(out_valid === 1'b0, "R4", "unexpected out_valid",
                    longint'(out_valid), 0);
                chk(done === 1'b0, "R7", "unexpected done",
                    longint'(done), 0);
            end
        end
    end

    task automatic load_weights();
        for (int k = 0; k < K; k++) begin
            for (int t = 0; t < K; t++) begin
                wt_we   = 1'b1;
                wt_addr = AW'(k*K + t);
                wt_data = 8'(wk[k][t]);
                @(negedge clk);
            end
        end
        wt_we = 1'b0;
    endtask

    // driver: pushes expectations, then streams every band
    task automatic run_image(input string req, input bit mid_en, input bit mid_wt);
        longint cstart;
        cstart = cyc;
        for (int b = 0; b < BANDS; b++) begin
            for (int o = 0; o < N - K + 1; o++) begin
                exp_t e;
                int   acc;
                acc = 0;
                for (int k = 0; k < K; k++)
                    for (int t = 0; t < K; t++)
                        acc += wk[k][t] * img[b+k][o+t];
                e.data = acc;
                e.last = (b == BANDS-1) && (o == N-K);
                e.due  = cstart + 1 + b*N + o + K;
                e.col  = o;
                e.req  = req;
                sb.push_back(e);
            end
        end
        for (int b = 0; b < BANDS; b++) begin
            for (int c = 0; c < N; c++) begin
                int s;
                s = b*N + c;
                for (int k = 0; k < K; k++)
                    pix_in[k*8 +: 8] = 8'(img[b+k][c]);
                en      = (s == 0) || (mid_en && (s % 7 == 3));
                wt_we   = mid_wt && (s % 5 == 2);
                wt_addr = AW'(s % (K*K));
                wt_data = 8'd55;
                @(negedge clk);
            end
        end
        en     = 1'b0;
        wt_we  = 1'b0;
        pix_in = K*8'($urandom);
    endtask

    task automatic fill_img(input int mode);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                case (mode)
                    0: img[r][c] = r*N + c - 20;
                    1: img[r][c] = int'($urandom_range(0, 255)) - 128;
                    default: img[r][c] = -128;
                endcase
    endtask

    initial begin
        n_chk   = 0;
        n_fail  = 0;
        cyc     = 0;
        mon_on  = 1'b0;
        rst     = 1'b1;
        en      = 1'b0;
        pix_in  = '0;
        wt_we   = 1'b0;
        wt_addr = '0;
        wt_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(out_valid === 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        chk(done === 1'b0, "R1", "done after reset", longint'(done), 0);
        chk(out_data === 20'd0, "R1", "out_data after reset", longint'(out_data), 0);
        mon_on = 1'b1;
        repeat (4) @(negedge clk);

        // R2: mixed kernel, ramp image
        wk = '{'{1, -2, 3}, '{-4, 5, -6}, '{7, -8, 9}};
        load_weights();
        fill_img(0);
        run_image("R2", 1'b0, 1'b0);
        // R5: back-to-back run with random pixels
        fill_img(1);
        run_image("R2", 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R6: en pulses while streaming
        fill_img(1);
        run_image("R6", 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        // R8: weight writes during streaming must be dropped
        fill_img(1);
        run_image("R8", 1'b0, 1'b1);
        fill_img(0);
        run_image("R8", 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        // R8: idle write takes effect
        wk = '{'{-3, 0, 2}, '{11, -1, 4}, '{0, 6, -9}};
        load_weights();
        fill_img(1);
        run_image("R8", 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        // R9: extremes
        wk = '{'{-128, -128, -128}, '{-128, -128, -128}, '{-128, -128, -128}};
        load_weights();
        fill_img(2);
        run_image("R9", 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        wk = '{'{127, 127, 127}, '{127, 127, 127}, '{127, 127, 127}};
        load_weights();
        run_image("R9", 1'b0, 1'b0);

        while (sb.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule